// File: doc/BRIEF.md
# Sparse Lazily-Backed Memory

This block answers loads and stores across a wide logical address window while holding only a few physical pages of storage. The window is cut into 4096-byte pages. A page gets a backing slot the first time a store puts a nonzero value into it, as long as the backing budget allows. A fully associative table of page tags maps each logical page number to its slot. Pages that have no slot read back as zero. Stores to such a page are dropped when the value is zero or the budget is used up.

Each request carries an address, a direction, a byte count and up to eight bytes of data. The block looks up the page and merges the write bytes in the request cycle. It registers the response one cycle later. A synchronous reset releases every slot, so the whole window reads as zero again and the full budget is available. Test harnesses use the block as a target that accepts any address pattern and costs little storage.

Top module: `sparse_mem`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rsp_valid` is 0. After reset every page reads as zero.
- R2: The page number is `req_addr[ADDR_W-1:12]` and the byte offset is `req_addr[11:0]`. Addresses with equal offsets on different pages refer to separate storage.
- R3: A legal read of a page with no slot returns `rsp_rdata` = 0.
- R4: A legal read of a mapped page returns the `req_size` bytes that start at the offset, in little-endian order: the byte at the lowest address goes to bits 7:0. All bits above 8*`req_size` are zero.
- R5: A legal write to an unmapped page takes a new slot only if the bytes it covers (the low `req_size` bytes of `req_wdata`) are nonzero and pages_in_use + 1 < `BUDGET_PAGES`. Pages in use go up by exactly one for each allocation.
- R6: A write to an unmapped page that does not get a slot has no effect. That page, and every other page, reads back unchanged.
- R7: A newly mapped page holds zero in every byte the allocating write did not cover. This holds even when the slot was used before a reset.
- R8: A legal write to an already mapped page always updates its covered bytes, even when the value is zero.
- R9: A request is legal only when `req_size` is 1, 2, 4 or 8 and `req_addr` is a multiple of `req_size`. Any other request, including one whose bytes would cross a page boundary, returns `rsp_err` = 1 and `rsp_rdata` = 0, and writes nothing.
- R10: Each cycle with `req_valid` high produces `rsp_valid` high on the next cycle, and a cycle without a request produces `rsp_valid` low. Write responses carry `rsp_rdata` = 0.
- R11: After a reset, the full budget of `BUDGET_PAGES`-1 pages can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; releases all pages |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address in the logical window |
| req_size | input | 4 | Byte count, 1/2/4/8 |
| req_wdata | input | 64 | Store data, low `req_size` bytes used |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Load data, right-aligned, zero-extended |
| rsp_err | output | 1 | Previous request was illegal |

## Verification
The hardest state to reach from the ports is an exhausted budget, followed by a reset and reuse of the same physical slots. Stale words left from earlier pages must then read as zero. The stimulus fills every slot with data in several words and confirms that further nonzero stores are refused. It then resets and maps new pages in the same lowest-first slot order. Finally it reads words the new owners never wrote, which exposes any stale data that survived.

// File: rtl/sparse_mem_pkg.sv
package sparse_mem_pkg;
   localparam int unsigned LANES  = 8;
   localparam int unsigned WORD_W = 8 * LANES;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [LANES-1:0]  lane_t;

   // true when the byte count is a supported power of two
   function automatic logic size_ok(input logic [3:0] sz);
      return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
   endfunction

   // true when the low address bits are aligned to the byte count
   function automatic logic aligned_ok(input logic [2:0] lo, input logic [3:0] sz);
      logic r;
      case (sz)
         4'd2:    r = (lo[0] == 1'b0);
         4'd4:    r = (lo[1:0] == 2'b00);
         4'd8:    r = (lo == 3'b000);
         default: r = 1'b1;
      endcase
      return r;
   endfunction

   // low-justified lane mask covering sz bytes
   function automatic lane_t low_lanes(input logic [3:0] sz);
      lane_t m;
      for (int i = 0; i < int'(LANES); i++) begin
         m[i] = (4'(i) < sz);
      end
      return m;
   endfunction
endpackage

// File: rtl/sparse_req_decode.sv
module sparse_req_decode
   import sparse_mem_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_OFS_W = 12,
   localparam int unsigned PAGE_W    = ADDR_W - PAGE_OFS_W,
   localparam int unsigned WIDX_W    = PAGE_OFS_W - 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        size,
   input  word_t             wdata,
   input  word_t             rd_word,
   output logic [PAGE_W-1:0] page,
   output logic [WIDX_W-1:0] widx,
   output lane_t             lanes,
   output word_t             wdata_pos,
   output logic              legal,
   output logic              wr_nonzero,
   output word_t             rd_value
);
   logic [2:0] lo;
   lane_t      cov_lanes;
   word_t      cov_bits;

   assign page = addr[ADDR_W-1:PAGE_OFS_W];
   assign widx = addr[PAGE_OFS_W-1:3];
   assign lo   = addr[2:0];

   assign cov_lanes = low_lanes(size);

   // expand lane mask into a bit mask
   for (genvar b = 0; b < int'(LANES); b++) begin : g_expand
      assign cov_bits[b*8 +: 8] = {8{cov_lanes[b]}};
   end

   assign legal      = size_ok(size) && aligned_ok(lo, size);
   assign lanes      = cov_lanes << lo;
   assign wdata_pos  = wdata << {lo, 3'b000};
   assign wr_nonzero = |(wdata & cov_bits);
   assign rd_value   = (rd_word >> {lo, 3'b000}) & cov_bits;
endmodule

// File: rtl/sparse_page_table.sv
module sparse_page_table #(
   parameter int unsigned PAGE_W       = 20,
   parameter int unsigned BUDGET_PAGES = 4,
   parameter bit          LOW_FIRST    = 1'b1,
   localparam int unsigned NSLOT       = BUDGET_PAGES - 1,
   localparam int unsigned SLOT_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int unsigned CNT_W       = $clog2(BUDGET_PAGES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PAGE_W-1:0] lk_page,
   input  logic              alloc_req,
   output logic              hit,
   output logic [SLOT_W-1:0] hit_slot,
   output logic              alloc_ok,
   output logic [SLOT_W-1:0] alloc_slot,
   output logic [CNT_W-1:0]  used_cnt
);
   localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(BUDGET_PAGES);

   logic [NSLOT-1:0]  vld_q;
   logic [PAGE_W-1:0] tag_q [NSLOT];
   logic [NSLOT-1:0]  match;
   logic              room;

   // parallel tag compare
   for (genvar s = 0; s < int'(NSLOT); s++) begin : g_cmp
      assign match[s] = vld_q[s] && (tag_q[s] == lk_page);
   end

   assign hit = |match;

   always_comb begin
      hit_slot = '0;
      for (int s = 0; s < int'(NSLOT); s++) begin
         if (match[s]) hit_slot = hit_slot | SLOT_W'(s);
      end
   end

   // free-slot search direction chosen at elaboration
   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         alloc_slot = '0;
         for (int s = int'(NSLOT) - 1; s >= 0; s--) begin
            if (!vld_q[s]) alloc_slot = SLOT_W'(s);
         end
      end
   end else begin : g_high_first
      always_comb begin
         alloc_slot = '0;
         for (int s = 0; s < int'(NSLOT); s++) begin
            if (!vld_q[s]) alloc_slot = SLOT_W'(s);
         end
      end
   end

   // strict budget test: one more page must stay below the limit
   assign room     = (({1'b0, used_cnt} + {{CNT_W{1'b0}}, 1'b1}) < LIMIT) && !(&vld_q);
   assign alloc_ok = alloc_req && !hit && room && !rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q    <= '0;
         used_cnt <= '0;
      end else if (alloc_ok) begin
         vld_q[alloc_slot] <= 1'b1;
         tag_q[alloc_slot] <= lk_page;
         used_cnt          <= used_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sparse_slot_store.sv
module sparse_slot_store
   import sparse_mem_pkg::*;
#(
   parameter int unsigned NSLOT  = 3,
   parameter int unsigned SLOT_W = 2,
   parameter int unsigned WIDX_W = 9,
   localparam int unsigned WPP   = 1 << WIDX_W,
   localparam int unsigned DEPTH = NSLOT * WPP
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SLOT_W-1:0] slot,
   input  logic [WIDX_W-1:0] widx,
   input  logic              wr_en,
   input  logic              fresh,
   input  lane_t             wr_lanes,
   input  word_t             wr_data,
   output word_t             rd_word
);
   word_t          mem_q [DEPTH];
   logic [WPP-1:0] wv_q  [NSLOT];
   logic           cur_valid;
   word_t          cur_word;
   word_t          base;
   word_t          merged;

   assign cur_valid = wv_q[slot][widx];
   assign cur_word  = mem_q[{slot, widx}];
   // never-written words read as zero, so no bulk clear is needed
   assign rd_word   = cur_valid ? cur_word : '0;
   assign base      = (fresh || !cur_valid) ? '0 : cur_word;

   for (genvar b = 0; b < int'(LANES); b++) begin : g_merge
      assign merged[b*8 +: 8] = wr_lanes[b] ? wr_data[b*8 +: 8] : base[b*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{slot, widx}] <= merged;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < int'(NSLOT); s++) wv_q[s] <= '0;
      end else if (wr_en) begin
         if (fresh) wv_q[slot] <= {{(WPP-1){1'b0}}, 1'b1} << widx;
         else       wv_q[slot][widx] <= 1'b1;
      end
   end
endmodule

// File: rtl/sparse_mem.sv
module sparse_mem
   import sparse_mem_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned PAGE_OFS_W   = 12,
   parameter int unsigned BUDGET_PAGES = 4,
   parameter bit          LOW_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_size,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   output logic              rsp_err
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_OFS_W;
   localparam int unsigned WIDX_W = PAGE_OFS_W - 3;
   localparam int unsigned NSLOT  = BUDGET_PAGES - 1;
   localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int unsigned CNT_W  = $clog2(BUDGET_PAGES + 1);

   if (BUDGET_PAGES < 2) begin : g_bad_budget
      $error("BUDGET_PAGES must allow at least one page");
   end
   if (PAGE_OFS_W < 4) begin : g_bad_page
      $error("page must hold at least two words");
   end
   if (ADDR_W <= PAGE_OFS_W) begin : g_bad_addr
      $error("address must be wider than the page offset");
   end

   logic [PAGE_W-1:0] page;
   logic [WIDX_W-1:0] widx;
   lane_t             lanes;
   word_t             wdata_pos;
   logic              legal;
   logic              wr_nonzero;
   word_t             rd_word;
   word_t             rd_value;
   logic              hit;
   logic [SLOT_W-1:0] hit_slot;
   logic              alloc_ok;
   logic [SLOT_W-1:0] alloc_slot;
   logic [CNT_W-1:0]  used_cnt;
   logic              wr_try;
   logic              alloc_req;
   logic              wr_en;
   logic [SLOT_W-1:0] slot_sel;

   sparse_req_decode #(
      .ADDR_W     (ADDR_W),
      .PAGE_OFS_W (PAGE_OFS_W)
   ) u_dec (
      .addr       (req_addr),
      .size       (req_size),
      .wdata      (req_wdata),
      .rd_word    (rd_word),
      .page       (page),
      .widx       (widx),
      .lanes      (lanes),
      .wdata_pos  (wdata_pos),
      .legal      (legal),
      .wr_nonzero (wr_nonzero),
      .rd_value   (rd_value)
   );

   assign wr_try    = req_valid && req_write && legal && !rst;
   assign alloc_req = wr_try && wr_nonzero;

   sparse_page_table #(
      .PAGE_W       (PAGE_W),
      .BUDGET_PAGES (BUDGET_PAGES),
      .LOW_FIRST    (LOW_FIRST)
   ) u_tbl (
      .clk        (clk),
      .rst        (rst),
      .lk_page    (page),
      .alloc_req  (alloc_req),
      .hit        (hit),
      .hit_slot   (hit_slot),
      .alloc_ok   (alloc_ok),
      .alloc_slot (alloc_slot),
      .used_cnt   (used_cnt)
   );

   assign slot_sel = hit ? hit_slot : alloc_slot;
   assign wr_en    = wr_try && (hit || alloc_ok);

   sparse_slot_store #(
      .NSLOT  (NSLOT),
      .SLOT_W (SLOT_W),
      .WIDX_W (WIDX_W)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .slot     (slot_sel),
      .widx     (widx),
      .wr_en    (wr_en),
      .fresh    (alloc_ok),
      .wr_lanes (lanes),
      .wr_data  (wdata_pos),
      .rd_word  (rd_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !legal;
         rsp_rdata <= (req_valid && !req_write && legal && hit) ? rd_value : '0;
      end
   end
endmodule

// File: rtl/sparse_mem_chk.sv
module sparse_mem_chk #(
   parameter int unsigned BUDGET_PAGES = 4,
   parameter int unsigned CNT_W        = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             req_write,
   input logic [3:0]       req_size,
   input logic             rsp_valid,
   input logic [63:0]      rsp_rdata,
   input logic             rsp_err,
   input logic             alloc_ok,
   input logic [CNT_W-1:0] used_cnt
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (!rsp_valid && (used_cnt == '0)));

   assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid);

   assert_write_rsp_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_write) |=> (rsp_rdata == 64'd0));

   assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0));

   assert_byte_read_width_R4: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_write && (req_size == 4'd1)) |=> (rsp_rdata[63:8] == 56'd0));

   assert_budget_bound_R5: assert property (@(posedge clk) disable iff (rst)
      int'(used_cnt) < int'(BUDGET_PAGES));

   assert_alloc_step_R5: assert property (@(posedge clk) disable iff (rst)
      alloc_ok |=> (used_cnt == CNT_W'($past(used_cnt) + 1'b1)));

   assert_count_stable_R5: assert property (@(posedge clk) disable iff (rst)
      !alloc_ok |=> $stable(used_cnt));
endmodule

bind sparse_mem sparse_mem_chk #(
   .BUDGET_PAGES (BUDGET_PAGES),
   .CNT_W        (CNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_size  (req_size),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .rsp_err   (rsp_err),
   .alloc_ok  (alloc_ok),
   .used_cnt  (used_cnt)
);

// File: tb/sparse_mem_test.sv
`timescale 1ns/1ps
module sparse_mem_test;
   localparam int ADDR_W = 32;
   localparam int BUDGET = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [3:0]        req_size = 4'd1;
   logic [63:0]       req_wdata = '0;
   logic              rsp_valid;
   logic [63:0]       rsp_rdata;
   logic              rsp_err;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   // behavioural reference: byte map plus set of mapped pages
   byte unsigned m_byte [longint unsigned];
   bit           m_page [longint unsigned];
   int           m_used = 0;

   always #2 clk = ~clk;

   sparse_mem #(.ADDR_W(ADDR_W), .BUDGET_PAGES(BUDGET)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

   task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
      vectors++;
      if (got !== exp) begin
         misses++;
         $display("FAIL %s: got valid/err/data %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      m_byte.delete();
      m_page.delete();
      m_used = 0;
   endtask

   function automatic bit legal_req(input longint unsigned a, input int s);
      if (!(s == 1 || s == 2 || s == 4 || s == 8)) return 1'b0;
      return (a % longint'(s)) == 0;
   endfunction

   task automatic model_apply(input bit w, input longint unsigned a, input int s,
                              input logic [63:0] d, output logic [63:0] ed, output bit ee);
      longint unsigned pg;
      longint unsigned v;
      pg = a >> 12;
      ed = '0;
      ee = !legal_req(a, s);
      if (ee) return;
      if (!w) begin
         if (m_page.exists(pg))
            for (int i = 0; i < s; i++)
               if (m_byte.exists(a + i)) ed[8*i +: 8] = m_byte[a + i];
         return;
      end
      v = 0;
      for (int i = 0; i < s; i++) v |= longint'(d[8*i +: 8]) << (8*i);
      if (!m_page.exists(pg) && v != 0 && (m_used + 1) < BUDGET) begin
         m_page[pg] = 1'b1;
         m_used++;
         for (int i = 0; i < 4096; i++)
            if (m_byte.exists((pg << 12) + i)) m_byte.delete((pg << 12) + i);
      end
      if (m_page.exists(pg))
         for (int i = 0; i < s; i++) m_byte[a + i] = d[8*i +: 8];
   endtask

   task automatic xfer(input string tag, input bit w, input longint unsigned a,
                       input int s, input logic [63:0] d);
      logic [63:0] ed;
      bit          ee;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a[ADDR_W-1:0];
      req_size  = 4'(s);
      req_wdata = d;
      model_apply(w, a, s, d, ed, ee);
      @(posedge clk);
      #1;
      check(tag, {rsp_valid, rsp_err, rsp_rdata}, {1'b1, ee, ed});
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      check(tag, {rsp_valid, 65'd0}, 66'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      req_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 idle in reset", {rsp_valid, 65'd0}, 66'd0);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: got no finish expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      do_reset();
      idle("R10 no request");
      // R1 / R3: empty window
      xfer("R3 unmapped read", 1'b0, 64'h5000, 8, '0);
      xfer("R1 fresh window", 1'b0, 64'h1008, 4, '0);
      // R6: zero store to unmapped page is dropped
      xfer("R6 zero write", 1'b1, 64'h1008, 8, 64'h0);
      xfer("R6 still zero", 1'b0, 64'h1008, 8, '0);
      // R5 / R4: allocation and little-endian reads
      xfer("R5 alloc write", 1'b1, 64'h1008, 8, 64'h1122334455667788);
      xfer("R4 dword read", 1'b0, 64'h1008, 8, '0);
      xfer("R4 byte read", 1'b0, 64'h100B, 1, '0);
      xfer("R4 half read", 1'b0, 64'h100A, 2, '0);
      xfer("R4 word read", 1'b0, 64'h100C, 4, '0);
      xfer("R7 untouched low", 1'b0, 64'h1000, 8, '0);
      xfer("R7 untouched top", 1'b0, 64'h1FFC, 4, '0);
      // R8: zero store to mapped page updates
      xfer("R8 zero byte", 1'b1, 64'h100F, 1, 64'h0);
      xfer("R8 readback", 1'b0, 64'h1008, 8, '0);
      // R2: same offset other pages are separate
      xfer("R2 alias page3", 1'b0, 64'h3008, 8, '0);
      xfer("R2 alias page11", 1'b0, 64'h11008, 8, '0);
      // R5: only covered bytes decide allocation
      xfer("R5 covered byte", 1'b1, 64'h2003, 1, 64'h1FF);
      xfer("R4 merged word", 1'b0, 64'h2000, 4, '0);
      xfer("R6 uncovered only", 1'b1, 64'h3000, 1, 64'h100);
      xfer("R6 page3 empty", 1'b0, 64'h3000, 8, '0);
      // R5: fill the budget, then refuse
      xfer("R5 third page", 1'b1, 64'hFFFF_F000, 4, 64'hCAFEF00D);
      xfer("R4 high page", 1'b0, 64'hFFFF_F000, 4, '0);
      xfer("R5 over budget", 1'b1, 64'h7010, 8, 64'hDEAD);
      xfer("R6 refused page", 1'b0, 64'h7010, 8, '0);
      xfer("R8 full still writes", 1'b1, 64'h1010, 2, 64'hBEEF);
      xfer("R8 full readback", 1'b0, 64'h1010, 2, '0);
      // R9: illegal requests
      xfer("R9 misaligned word", 1'b1, 64'h1002, 4, 64'hFFFFFFFF);
      xfer("R9 odd size", 1'b1, 64'h1008, 3, 64'hFFFFFF);
      xfer("R9 page crossing", 1'b1, 64'h1FFC, 8, 64'h1);
      xfer("R9 no write done", 1'b0, 64'h1000, 8, '0);
      xfer("R9 no write done2", 1'b0, 64'h1008, 8, '0);
      xfer("R9 misaligned read", 1'b0, 64'h1009, 2, '0);
      xfer("R9 size zero", 1'b0, 64'h1008, 0, '0);
      idle("R10 gap");
      // R11 / R7: reset frees slots; reused slot shows no stale words
      do_reset();
      xfer("R1 cleared", 1'b0, 64'h1008, 8, '0);
      xfer("R11 realloc a", 1'b1, 64'h5000, 8, 64'h0102030405060708);
      xfer("R7 stale word", 1'b0, 64'h5008, 8, '0);
      xfer("R7 stale word2", 1'b0, 64'h5010, 8, '0);
      xfer("R11 realloc b", 1'b1, 64'h6FF8, 8, 64'h55);
      xfer("R11 realloc c", 1'b1, 64'h7000, 1, 64'h9);
      xfer("R11 read a", 1'b0, 64'h5000, 8, '0);
      xfer("R11 read b", 1'b0, 64'h6FF8, 8, '0);
      xfer("R11 read c", 1'b0, 64'h7000, 1, '0);
      xfer("R5 budget again", 1'b1, 64'h8000, 4, 64'h1);
      xfer("R6 budget again", 1'b0, 64'h8000, 4, '0);
      for (int i = 0; i < 16; i++) begin
         xfer("R4 sweep write", 1'b1, 64'h5000 + 8 * i, 8, 64'h1111 * (i + 1));
         xfer("R4 sweep read", 1'b0, 64'h5000 + 8 * i + 4, 4, '0);
      end
      idle("R10 end");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule